// File: doc/BRIEF.md
# CAN Transceiver Mode and Supply-Fault Sequencer

This block is the digital control core of a CAN physical-layer interface. It chooses between an active (normal) mode, in which the transmitter and the full-speed receiver run, and a low-power standby mode, in which the bus is held at ground bias and only a wake detector listens. A host picks the mode with a single select pin. Undervoltage flags from the supply monitors override that choice. A deep undervoltage cuts the interface off the bus entirely.

Leaving standby is never immediate. The block passes through a settling phase of a fixed number of clock cycles before it enables the bus drivers. The same phase applies when it comes back after a supply fault. After any supply fault, the transmitter stays blocked until the transmit data line has been seen released (high). A stuck-low line therefore cannot drive a dominant level onto the bus the moment power returns. The select pin and the three supply flags pass through two-flop synchronizers before use. The wake flag, bus level and transmit data line are taken as already synchronous to the clock.

Top module: `can_mode_ctrl`

## Requirements
- R1: While reset is held and after it is released, the block sits in standby: `mode_nrm_o`, `tx_en_o`, `rx_en_o` and `bias_on_o` are 0 and `rxd_o` is 1.
- R2: With no fault flag set, a select level of 0 (normal) that has been stable since the driving clock edge makes `mode_nrm_o`, `rx_en_o` and `bias_on_o` rise at the (3 + SETTLE_CYC)-th rising clock edge after the input changed. The first two edges are the synchronizer and the third enters the settling phase.
- R3: During the settling phase, `mode_nrm_o` and `tx_en_o` stay 0 and `rxd_o` stays 1.
- R4: In normal mode, `rxd_o` is 0 while `bus_dom_i` is 1 (dominant) and 1 while it is 0 (recessive), with no clock delay.
- R5: A select level of 1 (standby) drops `mode_nrm_o`, `tx_en_o`, `rx_en_o` and `bias_on_o` at the third rising edge after the input changed.
- R6: In standby, `rxd_o` is 1 until `wake_i` has been seen high at a clock edge while in standby. From the following cycle, `rxd_o` equals the inverse of `bus_dom_i` until standby is left.
- R7: `uv_stby_i` or `uv_io_i` set to 1 forces standby at the third rising edge, whatever the select pin says.
- R8: `uv_off_i` set to 1 disengages the block at the third rising edge: all enables 0, `rxd_o` held at 1, and `wake_i` ignored until the flag clears.
- R9: After a fault clears, the return to normal takes the full settling time, measured from standby. From switch-off the return takes one extra cycle.
- R10: After any undervoltage flag has been seen, `tx_en_o` stays 0 in normal mode until `txd_i` has been seen high at a clock edge with no flag active. `tx_en_o` then rises at that edge.
- R11: A select level of 1 or a fault that reaches the controller during settling aborts the settling phase and returns to standby. The next attempt takes the full delay again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_sel_i | input | 1 | Mode select pin: 1 standby, 0 normal (asynchronous) |
| uv_stby_i | input | 1 | Main supply below standby threshold (asynchronous) |
| uv_off_i | input | 1 | Main supply below switch-off threshold (asynchronous) |
| uv_io_i | input | 1 | I/O supply undervoltage (asynchronous) |
| wake_i | input | 1 | Filtered wake pattern detected on the bus |
| bus_dom_i | input | 1 | Filtered bus level: 1 dominant, 0 recessive |
| txd_i | input | 1 | Transmit data line: 0 dominant, 1 recessive |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Full-speed receiver enable |
| bias_on_o | output | 1 | 1 selects mid-supply bus bias, 0 ground bias |
| rxd_o | output | 1 | Receive data pin level |
| mode_nrm_o | output | 1 | 1 while the block is in normal mode |

## Verification
The hardest situation to reach from the ports is a fault that arrives partway through the settling phase, followed by recovery while the transmit line is still held low. Hitting it needs cycle-exact placement of the fault against the synchronizer latency. The directed part of the bench places a standby undervoltage a few cycles into settling, holds `txd_i` low across the recovery, and releases it only after normal mode is back. The random phase then toggles faults and the select pin at rates that make such overlaps common, and a cycle model in the bench follows every output.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_STBY   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_NORM   = 2'd3
  } cmc_state_t;

  localparam int unsigned SYNC_W   = 4;
  localparam int unsigned IX_STBY  = 0;
  localparam int unsigned IX_UVS   = 1;
  localparam int unsigned IX_UVIO  = 2;
  localparam int unsigned IX_OFF   = 3;
  localparam logic [SYNC_W-1:0] SYNC_RST = 4'b0001;
endpackage

// File: rtl/cmc_sync.sv
module cmc_sync #(
  parameter int unsigned WIDTH = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end
endmodule

// File: rtl/cmc_timer.sv
module cmc_timer #(
  parameter int unsigned CYCLES = 4000,
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start_i || (cnt_q != '0);
    cnt_d  = start_i ? LOAD : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/cmc_fsm.sv
module cmc_fsm
  import cmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_stby,
  input  logic       s_flt,
  input  logic       s_off,
  input  logic       tmr_done,
  input  logic       wake_i,
  input  logic       txd_i,
  output cmc_state_t st_q,
  output logic       tmr_start,
  output logic       wk_q,
  output logic       blk_q
);
  cmc_state_t st_d;
  logic       wk_d, blk_d;

  always_comb begin
    st_d      = st_q;
    tmr_start = 1'b0;
    if (s_off) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF:    st_d = ST_STBY;
        ST_STBY:   if (!s_stby && !s_flt) begin
                     st_d      = ST_SETTLE;
                     tmr_start = 1'b1;
                   end
        ST_SETTLE: if (s_stby || s_flt) st_d = ST_STBY;
                   else if (tmr_done)   st_d = ST_NORM;
        ST_NORM:   if (s_stby || s_flt) st_d = ST_STBY;
        default:   st_d = ST_STBY;
      endcase
    end
  end

  always_comb begin
    wk_d = wk_q;
    if (st_q != ST_STBY) wk_d = 1'b0;
    else if (wake_i)     wk_d = 1'b1;

    blk_d = blk_q;
    if (s_off || s_flt) blk_d = 1'b1;
    else if (txd_i)     blk_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_STBY;
      wk_q  <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      wk_q  <= wk_d;
      blk_q <= blk_d;
    end
  end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_sel_i,
  input  logic uv_stby_i,
  input  logic uv_off_i,
  input  logic uv_io_i,
  input  logic wake_i,
  input  logic bus_dom_i,
  input  logic txd_i,
  output logic tx_en_o,
  output logic rx_en_o,
  output logic bias_on_o,
  output logic rxd_o,
  output logic mode_nrm_o
);
  logic [SYNC_W-1:0] raw, syn;
  logic s_stby, s_uvs, s_uvio, s_off, s_flt;
  logic tmr_start, tmr_done, wk_q, blk_q;
  cmc_state_t st_q;

  always_comb begin
    raw          = '0;
    raw[IX_STBY] = stby_sel_i;
    raw[IX_UVS]  = uv_stby_i;
    raw[IX_UVIO] = uv_io_i;
    raw[IX_OFF]  = uv_off_i;
  end

  cmc_sync #(.WIDTH(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(syn)
  );

  assign s_stby = syn[IX_STBY];
  assign s_uvs  = syn[IX_UVS];
  assign s_uvio = syn[IX_UVIO];
  assign s_off  = syn[IX_OFF];
  assign s_flt  = s_uvs | s_uvio;

  cmc_timer #(.CYCLES(SETTLE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start_i(tmr_start), .done_o(tmr_done)
  );

  cmc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .s_stby(s_stby), .s_flt(s_flt), .s_off(s_off),
    .tmr_done(tmr_done), .wake_i(wake_i), .txd_i(txd_i),
    .st_q(st_q), .tmr_start(tmr_start), .wk_q(wk_q), .blk_q(blk_q)
  );

  always_comb begin
    mode_nrm_o = (st_q == ST_NORM);
    rx_en_o    = mode_nrm_o;
    bias_on_o  = mode_nrm_o;
    tx_en_o    = mode_nrm_o && !blk_q;
    unique case (st_q)
      ST_NORM: rxd_o = !bus_dom_i;
      ST_STBY: rxd_o = wk_q ? !bus_dom_i : 1'b1;
      default: rxd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic s_stby,
  input logic s_flt,
  input logic s_off,
  input logic wk_q,
  input logic bus_dom_i,
  input logic txd_i,
  input logic tx_en_o,
  input logic rx_en_o,
  input logic bias_on_o,
  input logic rxd_o,
  input logic mode_nrm_o
);
  a_r4_rxd_tracks_bus: assert property (@(posedge clk) disable iff (!rst_n)
    mode_nrm_o |-> (rxd_o == !bus_dom_i));

  a_r5_select_leaves_normal: assert property (@(posedge clk) disable iff (!rst_n)
    s_stby |=> !mode_nrm_o);

  a_r7_fault_forces_standby: assert property (@(posedge clk) disable iff (!rst_n)
    s_flt |=> (!mode_nrm_o && !tx_en_o));

  a_r8_off_disengages: assert property (@(posedge clk) disable iff (!rst_n)
    s_off |=> (!mode_nrm_o && !bias_on_o && !rx_en_o && !tx_en_o && rxd_o));

  a_r6_rxd_idle_without_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_nrm_o && !wk_q) |-> rxd_o);

  a_r2_normal_needs_clear_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_nrm_o) |-> $past(!s_stby && !s_flt && !s_off));

  a_r10_tx_release_needs_txd_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_o && !$past(tx_en_o) && $past(mode_nrm_o)) |-> $past(txd_i));
endmodule

bind can_mode_ctrl can_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_stby(s_stby), .s_flt(s_flt), .s_off(s_off),
  .wk_q(wk_q), .bus_dom_i(bus_dom_i), .txd_i(txd_i), .tx_en_o(tx_en_o),
  .rx_en_o(rx_en_o), .bias_on_o(bias_on_o), .rxd_o(rxd_o), .mode_nrm_o(mode_nrm_o)
);

// File: tb/can_mode_ctrl_tb.sv
module can_mode_ctrl_tb;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby = 1'b1, uvs = 1'b0, uvoff = 1'b0, uvio = 1'b0;
  logic wake = 1'b0, bus = 1'b0, txd = 1'b1;
  logic tx_en, rx_en, bias, rxd, mode;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  can_mode_ctrl #(.SETTLE_CYC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .stby_sel_i(stby), .uv_stby_i(uvs), .uv_off_i(uvoff),
    .uv_io_i(uvio), .wake_i(wake), .bus_dom_i(bus), .txd_i(txd),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .bias_on_o(bias), .rxd_o(rxd), .mode_nrm_o(mode)
  );

  // Bench cycle model: 0 off, 1 standby, 2 settling, 3 normal
  logic [3:0] p1, p2;
  int m_st, m_cnt;
  bit m_wk, m_blk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 <= 4'b0001; p2 <= 4'b0001;
      m_st <= 1; m_cnt <= 0; m_wk <= 0; m_blk <= 0;
    end else begin
      bit off, flt, sel;
      sel = p2[0]; flt = p2[1] | p2[2]; off = p2[3];
      p1 <= {uvoff, uvio, uvs, stby};
      p2 <= p1;
      if (m_st != 1) m_wk <= 0; else if (wake) m_wk <= 1;
      if (off || flt) m_blk <= 1; else if (txd) m_blk <= 0;
      if (m_cnt > 0) m_cnt <= m_cnt - 1;
      if (off) m_st <= 0;
      else case (m_st)
        0: m_st <= 1;
        1: if (!sel && !flt) begin m_st <= 2; m_cnt <= N - 1; end
        2: if (sel || flt) m_st <= 1; else if (m_cnt == 0) m_st <= 3;
        default: if (sel || flt) m_st <= 1;
      endcase
    end
  end

  function automatic bit exp_rxd(int st, bit wk, bit b);
    if (st == 3) return !b;
    if (st == 1 && wk) return !b;
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(mode == (m_st == 3), "R2 mode model", mode, m_st == 3);
    chk(rx_en == (m_st == 3) && bias == (m_st == 3), "R5 enables model", {rx_en, bias}, {2{m_st == 3}});
    chk(tx_en == (m_st == 3 && !m_blk), "R10 tx_en model", tx_en, m_st == 3 && !m_blk);
    chk(rxd == exp_rxd(m_st, m_wk, bus), "R6 rxd model", rxd, exp_rxd(m_st, m_wk, bus));
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!mode && !tx_en && !rx_en && !bias && rxd, "R1 in reset", {mode, tx_en, rx_en, bias, rxd}, 1);
    rst_n = 1'b1;
    step();
    chk(!mode && !tx_en && !rx_en && !bias && rxd, "R1 after reset", {mode, tx_en, rx_en, bias, rxd}, 1);

    stby = 1'b0;
    steps(2 + N);
    chk(!mode && !tx_en && rxd, "R3 settling", {mode, tx_en, rxd}, 3'b001);
    step();
    chk(mode && rx_en && bias && tx_en, "R2 normal on time", {mode, rx_en, bias, tx_en}, 4'hf);

    bus = 1'b1; step();
    chk(rxd == 1'b0, "R4 dominant", rxd, 0);
    bus = 1'b0; step();
    chk(rxd == 1'b1, "R4 recessive", rxd, 1);

    stby = 1'b1; steps(2);
    chk(mode == 1'b1, "R5 not yet", mode, 1);
    step();
    chk(!mode && !tx_en && !rx_en && !bias, "R5 standby", {mode, tx_en, rx_en, bias}, 0);

    bus = 1'b1; step();
    chk(rxd == 1'b1, "R6 no wake", rxd, 1);
    wake = 1'b1; step();
    chk(rxd == 1'b0, "R6 wake follows", rxd, 0);
    wake = 1'b0; bus = 1'b0; step();
    chk(rxd == 1'b1, "R6 follows recessive", rxd, 1);
    bus = 1'b1; step();
    chk(rxd == 1'b0, "R6 follows dominant", rxd, 0);
    bus = 1'b0;

    stby = 1'b0; steps(3 + 5);
    uvs = 1'b1; txd = 1'b0; steps(3);
    chk(!mode && rxd, "R11 abort", {mode, rxd}, 1);
    steps(3 * N);
    chk(!mode, "R7 select ignored", mode, 0);
    uvs = 1'b0; steps(2 + N);
    chk(!mode, "R9 full delay", mode, 0);
    step();
    chk(mode && !tx_en, "R10 blocked", {mode, tx_en}, 2'b10);
    steps(4);
    chk(!tx_en, "R10 still blocked", tx_en, 0);
    txd = 1'b1; step();
    chk(tx_en, "R10 released", tx_en, 1);

    uvio = 1'b1; steps(3);
    chk(!mode && !tx_en, "R7 io fault", {mode, tx_en}, 0);
    uvio = 1'b0; steps(3 + N);
    chk(mode, "R9 io recovery", mode, 1);

    uvoff = 1'b1; steps(3);
    chk(!mode && !bias && !rx_en && rxd, "R8 off", {mode, bias, rx_en, rxd}, 1);
    wake = 1'b1; bus = 1'b1; steps(3);
    chk(rxd, "R8 wake ignored", rxd, 1);
    wake = 1'b0; bus = 1'b0;
    uvoff = 1'b0; steps(3 + N);
    chk(!mode, "R9 off recovery delay", mode, 0);
    step();
    chk(mode, "R9 off recovery", mode, 1);

    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(39) == 0) stby = ~stby;
      if ($urandom_range(uvs ? 20 : 300) == 0) uvs = ~uvs;
      if ($urandom_range(uvio ? 20 : 400) == 0) uvio = ~uvio;
      if ($urandom_range(uvoff ? 20 : 600) == 0) uvoff = ~uvoff;
      wake = ($urandom_range(9) == 0);
      bus  = $urandom_range(1);
      txd  = ($urandom_range(3) != 0);
      step();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule